// File: doc/BRIEF.md
# Framebuffer Pixel Unpacker

The unpacker sits between a video memory read path and a display pipeline. It accepts 32-bit words from a valid/ready stream and emits 24-bit RGB pixels on a second valid/ready stream. A two-bit depth code picks how pixels are packed in the words: 8, 16, 24 or 32 bits per pixel. In the 8-bit case a separate flag chooses between grayscale, where the byte becomes all three colour channels, and indexed colour, where the byte is sent out on a lookup port and the returned table entry becomes the pixel.

Inside, a position counter tracks which pixel of the current word (or of the current three-word group at 24 bits per pixel) comes next. A residual register keeps the bytes of a word that a later pixel still needs. A word is acknowledged only in the cycle its last pixel is taken. Configuration is sampled only while the unit is disabled. Disabling clears all partial state, and a frame-start pulse returns the position counter to the start of a group.

The control state machine has four states. OFF is held while `enable` is low. OFF goes to RUN on the first enabled cycle. In RUN, direct modes emit pixels. In indexed mode, RUN issues a lookup and goes to WAIT when the request is accepted. WAIT goes to HOLD when the response is accepted. HOLD presents the looked-up pixel and goes back to RUN when it is taken. From any state, a low `enable` returns the machine to OFF.

Top module: `fb_pixel_unpack`

## Requirements
- R1: While reset is asserted, and after it until the unit is enabled, `pix_valid`, `word_ready` and `lut_req_valid` are low.
- R2: Depth code 0 selects 8 bits per pixel, 1 selects 16, 2 selects 24 and 3 selects 32. `pseudo_en` has an effect only with code 0. Both inputs are sampled only while `enable` is low, so changes while enabled have no effect on decoding.
- R3: With code 3, each word gives one pixel equal to its bits [23:0]. The upper byte is ignored. Every output pixel carries red in [23:16], green in [15:8] and blue in [7:0].
- R4: With code 2, every three words W0, W1, W2 give four pixels, in this order: W0[31:8]; {W0[7:0],W1[31:16]}; {W1[15:0],W2[31:24]}; W2[23:0].
- R5: With code 1, each word gives two pixels, upper halfword first. Each halfword is RGB565 and is widened with zeros in the low bits: red 5→8, green 6→8, blue 5→8.
- R6: With code 0 and `pseudo_en` low, each word gives four pixels, from byte [31:24] down to [7:0]. Each byte is copied to red, green and blue.
- R7: With code 0 and `pseudo_en` high, each byte, in the same most-significant-first order, is presented on `lut_req_index`. The pixel is the 24-bit `lut_rsp_data` returned for that request.
- R8: Between acceptance of a lookup request and acceptance of its response, no pixel is offered. Each accepted response produces exactly one pixel, offered in the following cycle.
- R9: `word_ready` rises only with `word_valid` high, and only in the cycle the word's last pixel (or, at 24 bits, its last needed byte) is taken. Every pixel of a stream is emitted and no extra pixel appears.
- R10: One cycle after `enable` is seen low, no pixel, word acknowledge or lookup is offered. On re-enable, decoding restarts at the most significant pixel of the next word.
- R11: A `frame_start` pulse while enabled returns the position to the start of a word or group, so the next pixel is taken from a fresh word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Unit enable; low flushes and allows reconfiguration |
| frame_start | input | 1 | Pulse that restarts the pixel position |
| depth_sel | input | 2 | Depth code |
| pseudo_en | input | 1 | Indexed colour in 8-bit mode |
| word_valid | input | 1 | Input word present |
| word_ready | output | 1 | Input word consumed |
| word_data | input | 32 | Input word |
| pix_valid | output | 1 | Output pixel present |
| pix_ready | input | 1 | Output pixel taken |
| pix_data | output | 24 | Output pixel, red high |
| lut_req_valid | output | 1 | Lookup request present |
| lut_req_ready | input | 1 | Lookup request accepted |
| lut_req_index | output | 8 | Lookup index |
| lut_rsp_valid | input | 1 | Lookup response present |
| lut_rsp_ready | output | 1 | Unit waiting for a lookup response |
| lut_rsp_data | input | 24 | Lookup table entry colour |

## Verification
The bench targets the 24-bit group boundaries. A residual register that is loaded on the wrong pixel would splice bytes from the wrong word into pixels 1 and 2, and it shows up against fixed words with distinct bytes. It also targets the RGB565 widening and halfword order: a design that replicates bits or swaps halves produces nonzero low bits or transposed pixels. Indexed mode runs with random request acceptance and response latency. This would expose a design that offers a pixel early, drops a response, or presents the wrong byte as the index. Further directed cases cover a depth change while enabled, the pseudo flag with a non-8-bit code, and a disable or frame-start pulse in the middle of a word. Each of these would show up as pixels taken from the old position or old mode.

// File: rtl/fbpu_pkg.sv
package fbpu_pkg;
    localparam int WORD_W = 32;
    localparam int PIX_W  = 24;
    localparam int IDX_W  = 8;
    localparam int POS_W  = 2;

    typedef enum logic [1:0] {
        DEPTH_8  = 2'd0,
        DEPTH_16 = 2'd1,
        DEPTH_24 = 2'd2,
        DEPTH_32 = 2'd3
    } depth_e;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_RUN  = 2'd1,
        ST_WAIT = 2'd2,
        ST_HOLD = 2'd3
    } state_e;
endpackage

// File: rtl/fbpu_slice.sv
module fbpu_slice
    import fbpu_pkg::*;
(
    input  depth_e             depth,
    input  logic [POS_W-1:0]   pos,
    input  logic [WORD_W-1:0]  cur_word,
    input  logic [PIX_W-1:0]   resid,
    output logic [PIX_W-1:0]   pix,
    output logic [IDX_W-1:0]   idx,
    output logic               need_word,
    output logic               take_word,
    output logic               last
);
    logic [WORD_W-1:0] shifted;
    logic [15:0]       half;

    always_comb begin
        shifted   = cur_word << {pos, 3'b000};
        idx       = shifted[WORD_W-1 -: IDX_W];
        half      = pos[0] ? cur_word[15:0] : cur_word[31:16];
        pix       = '0;
        need_word = 1'b1;
        take_word = 1'b0;
        last      = 1'b0;
        unique case (depth)
            DEPTH_8: begin
                pix       = {idx, idx, idx};
                take_word = (pos == 2'd3);
                last      = (pos == 2'd3);
            end
            DEPTH_16: begin
                pix       = {half[15:11], 3'b000, half[10:5], 2'b00, half[4:0], 3'b000};
                take_word = pos[0];
                last      = pos[0];
            end
            DEPTH_24: begin
                unique case (pos)
                    2'd0: pix = cur_word[31:8];
                    2'd1: pix = {resid[7:0], cur_word[31:16]};
                    2'd2: pix = {resid[15:0], cur_word[31:24]};
                    2'd3: pix = resid[23:0];
                endcase
                need_word = (pos != 2'd3);
                take_word = (pos != 2'd3);
                last      = (pos == 2'd3);
            end
            DEPTH_32: begin
                pix       = cur_word[23:0];
                take_word = 1'b1;
                last      = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/fbpu_ctrl.sv
module fbpu_ctrl
    import fbpu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              frame_start,
    input  logic [1:0]        depth_in,
    input  logic              pseudo_in,
    input  logic              word_valid,
    input  logic [PIX_W-1:0]  word_low,
    input  logic              pix_ready,
    input  logic              lut_req_ready,
    input  logic              lut_rsp_valid,
    input  logic [PIX_W-1:0]  lut_rsp_data,
    input  logic              need_word,
    input  logic              take_word,
    input  logic              last,
    output depth_e            cfg_depth,
    output logic              cfg_pseudo8,
    output logic [POS_W-1:0]  pos,
    output logic [PIX_W-1:0]  resid,
    output logic [PIX_W-1:0]  hold_pix,
    output logic              word_ready,
    output logic              pix_valid,
    output logic              use_hold,
    output logic              lut_req_valid,
    output logic              lut_rsp_ready
);
    state_e state;
    logic   step;

    // output process
    always_comb begin
        word_ready    = 1'b0;
        pix_valid     = 1'b0;
        use_hold      = 1'b0;
        lut_req_valid = 1'b0;
        lut_rsp_ready = 1'b0;
        step          = 1'b0;
        unique case (state)
            ST_OFF: begin
            end
            ST_RUN: begin
                if (!frame_start) begin
                    if (cfg_pseudo8) begin
                        lut_req_valid = word_valid;
                        step          = word_valid && lut_req_ready;
                    end else begin
                        pix_valid = !need_word || word_valid;
                        step      = pix_valid && pix_ready;
                    end
                    word_ready = step && take_word;
                end
            end
            ST_WAIT: lut_rsp_ready = 1'b1;
            ST_HOLD: begin
                pix_valid = 1'b1;
                use_hold  = 1'b1;
            end
        endcase
    end

    // state register process
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_OFF;
            pos         <= '0;
            resid       <= '0;
            hold_pix    <= '0;
            cfg_depth   <= DEPTH_8;
            cfg_pseudo8 <= 1'b0;
        end else if (!enable) begin
            state       <= ST_OFF;
            pos         <= '0;
            resid       <= '0;
            cfg_depth   <= depth_e'(depth_in);
            cfg_pseudo8 <= pseudo_in && (depth_in == 2'd0);
        end else begin
            if (frame_start) begin
                pos <= '0;
            end
            unique case (state)
                ST_OFF: state <= ST_RUN;
                ST_RUN: begin
                    if (step) begin
                        pos <= last ? '0 : pos + 1'b1;
                        if (take_word) resid <= word_low;
                        if (cfg_pseudo8) state <= ST_WAIT;
                    end
                end
                ST_WAIT: begin
                    if (lut_rsp_valid) begin
                        hold_pix <= lut_rsp_data;
                        state    <= ST_HOLD;
                    end
                end
                ST_HOLD: if (pix_ready) state <= ST_RUN;
            endcase
        end
    end

    // R10
    off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !(pix_valid || word_ready || lut_req_valid));

    // R9
    word_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        word_ready |-> word_valid);
endmodule

// File: rtl/fb_pixel_unpack.sv
module fb_pixel_unpack
    import fbpu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              frame_start,
    input  logic [1:0]        depth_sel,
    input  logic              pseudo_en,
    input  logic              word_valid,
    output logic              word_ready,
    input  logic [WORD_W-1:0] word_data,
    output logic              pix_valid,
    input  logic              pix_ready,
    output logic [PIX_W-1:0]  pix_data,
    output logic              lut_req_valid,
    input  logic              lut_req_ready,
    output logic [IDX_W-1:0]  lut_req_index,
    input  logic              lut_rsp_valid,
    output logic              lut_rsp_ready,
    input  logic [PIX_W-1:0]  lut_rsp_data
);
    depth_e             cfg_depth;
    logic               cfg_pseudo8;
    logic [POS_W-1:0]   pos;
    logic [PIX_W-1:0]   resid;
    logic [PIX_W-1:0]   hold_pix;
    logic [PIX_W-1:0]   slice_pix;
    logic               need_word, take_word, last, use_hold;

    fbpu_slice u_slice (
        .depth     (cfg_depth),
        .pos       (pos),
        .cur_word  (word_data),
        .resid     (resid),
        .pix       (slice_pix),
        .idx       (lut_req_index),
        .need_word (need_word),
        .take_word (take_word),
        .last      (last)
    );

    fbpu_ctrl u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .enable        (enable),
        .frame_start   (frame_start),
        .depth_in      (depth_sel),
        .pseudo_in     (pseudo_en),
        .word_valid    (word_valid),
        .word_low      (word_data[PIX_W-1:0]),
        .pix_ready     (pix_ready),
        .lut_req_ready (lut_req_ready),
        .lut_rsp_valid (lut_rsp_valid),
        .lut_rsp_data  (lut_rsp_data),
        .need_word     (need_word),
        .take_word     (take_word),
        .last          (last),
        .cfg_depth     (cfg_depth),
        .cfg_pseudo8   (cfg_pseudo8),
        .pos           (pos),
        .resid         (resid),
        .hold_pix      (hold_pix),
        .word_ready    (word_ready),
        .pix_valid     (pix_valid),
        .use_hold      (use_hold),
        .lut_req_valid (lut_req_valid),
        .lut_rsp_ready (lut_rsp_ready)
    );

    assign pix_data = use_hold ? hold_pix : slice_pix;

    // R8
    req_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lut_req_valid && lut_req_ready && enable) |=> !pix_valid);

    // R8
    rsp_pixel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lut_rsp_valid && lut_rsp_ready && enable) |=>
            (pix_valid && pix_data == $past(lut_rsp_data)));

    // R5
    rgb565_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && !use_hold && cfg_depth == DEPTH_16) |->
            (pix_data[2:0] == 3'b000 && pix_data[9:8] == 2'b00 && pix_data[18:16] == 3'b000));

    // R2
    lookup_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lut_req_valid |-> (cfg_depth == DEPTH_8 && !pix_valid));
endmodule

// File: tb/fb_pixel_unpack_test.sv
`timescale 1ns/1ps
module fb_pixel_unpack_test;
    logic        clk = 1'b0, rst_n = 1'b0, enable = 1'b0, frame_start = 1'b0;
    logic [1:0]  depth_sel = 2'd0;
    logic        pseudo_en = 1'b0, word_valid = 1'b0, pix_ready = 1'b0;
    logic [31:0] word_data = '0;
    logic        lut_req_ready = 1'b0, lut_rsp_valid = 1'b0;
    logic [23:0] lut_rsp_data = '0;
    logic        word_ready, pix_valid, lut_req_valid, lut_rsp_ready;
    logic [23:0] pix_data;
    logic [7:0]  lut_req_index;

    fb_pixel_unpack uut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .frame_start(frame_start),
        .depth_sel(depth_sel), .pseudo_en(pseudo_en),
        .word_valid(word_valid), .word_ready(word_ready), .word_data(word_data),
        .pix_valid(pix_valid), .pix_ready(pix_ready), .pix_data(pix_data),
        .lut_req_valid(lut_req_valid), .lut_req_ready(lut_req_ready),
        .lut_req_index(lut_req_index), .lut_rsp_valid(lut_rsp_valid),
        .lut_rsp_ready(lut_rsp_ready), .lut_rsp_data(lut_rsp_data)
    );

    always #4 clk = ~clk;

    int checks = 0, errors = 0;
    logic [31:0] words [0:47];
    int nw = 0, wi = 0, got = 0, total = 0, ed = 0, dly = 0;
    bit ep = 0, gaps = 0, pend = 0, fs_req = 0;
    logic [7:0] pidx = '0;

    function automatic logic [23:0] lutf(input logic [7:0] b);
        return {b ^ 8'h3C, ~b, b + 8'd7};
    endfunction

    function automatic logic [7:0] byte_of(input int i);
        logic [31:0] w;
        w = words[i / 4] >> (24 - 8 * (i % 4));
        return w[7:0];
    endfunction

    function automatic logic [23:0] exp_pix(input int i);
        logic [15:0] h;
        int b;
        b = (i / 4) * 3;
        case (ed)
            0: return ep ? lutf(byte_of(i)) : {byte_of(i), byte_of(i), byte_of(i)};
            1: begin
                h = (i % 2 == 0) ? words[i / 2][31:16] : words[i / 2][15:0];
                return {h[15:11], 3'b000, h[10:5], 2'b00, h[4:0], 3'b000};
            end
            2: case (i % 4)
                0: return words[b][31:8];
                1: return {words[b][7:0], words[b + 1][31:16]};
                2: return {words[b + 1][15:0], words[b + 2][31:24]};
                default: return words[b + 2][23:0];
            endcase
            default: return words[i][23:0];
        endcase
    endfunction

    function automatic string tag_of();
        if (ep) return "R7";
        case (ed)
            0: return "R6";
            1: return "R5";
            2: return "R4";
            default: return "R3";
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cycle();
        @(negedge clk);
        frame_start   = fs_req;
        word_valid    = (wi < nw) && (!gaps || ($urandom % 4 != 0));
        word_data     = (wi < nw) ? words[wi] : $urandom;
        pix_ready     = !gaps || ($urandom % 3 != 0);
        lut_req_ready = !pend && ($urandom % 2 == 1);
        lut_rsp_valid = pend && (dly == 0);
        lut_rsp_data  = lutf(pidx);
        #1;
        if (pix_valid && pix_ready) begin
            if (got >= total) chk(1'b0, "R9 extra pixel", {8'h0, pix_data}, 32'h0);
            else chk(pix_data === exp_pix(got), tag_of(), {8'h0, pix_data}, {8'h0, exp_pix(got)});
            got++;
        end
        if (word_valid && word_ready) wi++;
        if (lut_req_valid && !ep) chk(1'b0, "R2 lookup outside indexed mode", 32'h1, 32'h0);
        if (lut_rsp_valid && lut_rsp_ready) pend = 0;
        else if (pend && dly > 0) dly--;
        if (lut_req_valid && lut_req_ready) begin
            chk(lut_req_index === byte_of(got), "R7 index", {24'h0, lut_req_index}, {24'h0, byte_of(got)});
            pend = 1;
            pidx = lut_req_index;
            dly  = $urandom % 3;
        end
    endtask

    task automatic configure(input int d, input bit ps);
        @(negedge clk);
        enable = 1'b0; word_valid = 1'b0; pix_ready = 1'b0; lut_req_ready = 1'b0; lut_rsp_valid = 1'b0;
        depth_sel = d[1:0];
        pseudo_en = ps;
        repeat (2) @(negedge clk);
        enable = 1'b1;
        ed = d;
        ep = ps && (d == 0);
    endtask

    task automatic load(input int n);
        for (int i = 0; i < n; i++) words[i] = $urandom;
        nw = n; wi = 0; got = 0;
        total = (ed == 0) ? n * 4 : (ed == 1) ? n * 2 : (ed == 2) ? (n / 3) * 4 : n;
    endtask

    task automatic run_until(input int target);
        int c = 0;
        while (got < target && c < 3000) begin
            cycle();
            c++;
        end
    endtask

    task automatic run_all();
        run_until(total);
        chk(got == total, "R9 pixel count", got, total);
        chk(wi == nw, "R9 words consumed", wi, nw);
        repeat (3) cycle();
    endtask

    initial begin
        #1200000;
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", got, total);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240));
        repeat (3) @(negedge clk);
        #1;
        chk(!pix_valid && !word_ready && !lut_req_valid, "R1 in reset",
            {pix_valid, word_ready, lut_req_valid}, 32'h0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        #1;
        chk(!pix_valid && !word_ready && !lut_req_valid, "R1 before enable",
            {pix_valid, word_ready, lut_req_valid}, 32'h0);

        // directed: 32-bit, top byte ignored (R3)
        configure(3, 0); load(2);
        words[0] = 32'hFF123456; words[1] = 32'hA5ABCDEF;
        run_all();
        // directed: 24-bit group splice (R4)
        configure(2, 0); load(3);
        words[0] = 32'h11223344; words[1] = 32'h55667788; words[2] = 32'h99AABBCC;
        run_all();
        // directed: RGB565 extremes (R5)
        configure(1, 0); load(2);
        words[0] = 32'hF80007E0; words[1] = 32'h001FFFFF;
        run_all();

        // random streams in every mode, without and with gaps
        for (int rep = 0; rep < 2; rep++) begin
            gaps = rep[0];
            for (int m = 0; m < 5; m++) begin
                configure(m == 4 ? 0 : m, m == 4);
                load(12);
                run_all();
            end
        end
        gaps = 1'b1;

        // R2: depth change while enabled is ignored
        configure(1, 0);
        depth_sel = 2'd3; pseudo_en = 1'b1;
        load(6); run_all();
        // R2: pseudo flag with 32-bit code has no effect
        configure(3, 1);
        load(6); run_all();

        // R11: frame start mid-group at 24 bits
        gaps = 1'b0;
        configure(2, 0); load(1); total = 1;
        run_until(1);
        fs_req = 1; cycle(); fs_req = 0;
        load(3); run_all();

        // R10: disable mid-word flushes position
        configure(0, 0); load(1);
        run_until(2);
        @(negedge clk);
        enable = 1'b0; word_valid = 1'b0;
        @(negedge clk);
        word_valid = 1'b1; word_data = words[0]; pix_ready = 1'b1;
        #1;
        chk(!pix_valid && !word_ready, "R10 quiet when disabled", {pix_valid, word_ready}, 32'h0);
        configure(0, 0); load(3); run_all();

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule